// File: doc/BRIEF.md
# Serial FRAM Transaction Sequencer

This block sits behind a two-wire bus byte engine and in front of a synchronous single-port byte RAM. The byte engine reports Start and Stop conditions, each byte received from the bus master, the end of each byte shifted out, and the master's acknowledge bit. The sequencer decodes the device-select byte and runs write transactions: two address bytes, then any number of data bytes. It also runs reads from the current address, which may continue as sequential reads. A random read is a write-address phase followed by a repeated Start and a read device-select. For every received byte it returns an acknowledge decision one clock after the byte event.

A single address latch survives from one transaction to the next. It advances after every data byte, written or read, and wraps at the top of the array. When the write-protect input is high, the top quarter of the array is read-only. Data bytes aimed there are refused, the RAM is not written and the latch does not move. There is no page buffer and no busy time: a data byte is committed to the RAM in the same clock as its byte event. The read data for the current address is always fetched ahead of time, so the byte is ready when a read phase begins.

Top module: `fram_txn_ctrl`

## Requirements
- R1: After reset the address latch (visible on `ram_addr`) is 0, `ack_vld` and `tx_en` are low, and a read started before any write returns the byte stored at address 0.
- R2: A device-select byte matches when bits 7..4 equal `DEV_ID` (default 4'b1010) and bits 3..1 equal `sel_pins`. Bit 0 set to 1 selects a read and 0 selects a write. A matching byte is acknowledged. A non-matching byte is refused, and every later byte up to the next Start is refused without writing the RAM.
- R3: After a matching write select, the next two bytes load the address, high byte first. Only the low `ADDR_W-8` bits of the high byte are used. Both address bytes are acknowledged whatever the state of `wp`.
- R4: Each data byte after the address bytes is written to the RAM at the latched address and acknowledged, and the latch then advances by one. Any number of data bytes may follow.
- R5: The latch advances from the highest address (2^ADDR_W - 1) to 0.
- R6: With `wp` high, a data byte aimed at the top quarter (the two address MSBs both 1) is refused and not written, the latch does not move, and later bytes up to the next Start are refused. With `wp` low, the top quarter is writable.
- R7: After a matching read select, `tx_en` is high and `tx_data` carries the byte at the latched address. Each `ev_tx_done` advances the latch. A master acknowledge keeps the read going with the next byte, and a master no-acknowledge ends it (`tx_en` low).
- R8: A repeated Start after the two address bytes abandons the write. A read select that follows then returns data from the newly loaded address.
- R9: A Stop or Start before a data byte completes leaves the RAM unchanged. After a Stop, `tx_en` is low and received bytes are refused.
- R10: Bytes received without a preceding Start are refused.
- R11: The latch keeps its value across transactions, so a later read continues from where the last write or read ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pins | input | SEL_W | Device-select strap value |
| wp | input | 1 | Write protect for the top quarter |
| ev_start | input | 1 | Start or repeated Start seen (pulse) |
| ev_stop | input | 1 | Stop seen (pulse) |
| ev_byte_vld | input | 1 | A full byte received from the master (pulse) |
| ev_byte | input | 8 | Received byte |
| ev_tx_done | input | 1 | A read byte has been shifted out (pulse) |
| ev_mack_vld | input | 1 | Master acknowledge bit sampled (pulse) |
| ev_mack_ok | input | 1 | 1 = master acknowledged, 0 = no-acknowledge |
| ack_vld | output | 1 | Acknowledge decision valid, one clock after `ev_byte_vld` |
| ack_ok | output | 1 | 1 = acknowledge the byte, 0 = refuse |
| tx_en | output | 1 | Read phase active, byte engine may drive data |
| tx_data | output | 8 | Byte to shift out |
| ram_addr | output | ADDR_W | RAM address (the address latch) |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one clock after `ram_addr` |

## Verification
Writes are tried with several address patterns. One uses garbage in the unused high-address bits, which separates correct masking from a full 16-bit load. One crosses the top of the array, which separates wrapping from saturation. One starts one byte below the protected quarter with `wp` high, which separates a per-byte protection check from a per-transaction one and shows that a refused byte leaves the latch in place. Reads are tried three ways: from a fresh reset, continuing after an earlier read, and after a repeated Start. Together these show whether the latch persists and whether the repeated Start takes the new address. Mismatched select bytes, bytes sent before any Start, and transactions aborted by Stop or Start confirm that nothing reaches the RAM outside an acknowledged write.

// File: rtl/fram_txn_pkg.sv
package fram_txn_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } txn_st_t;
endpackage

// File: rtl/fram_devsel_dec.sv
module fram_devsel_dec #(
  parameter int SEL_W = 3,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic [7:0]       sel_byte,
  input  logic [SEL_W-1:0] sel_pins,
  output logic             hit,
  output logic             rd
);
  localparam int ID_LSB = SEL_W + 1;

  function automatic logic id_match(input logic [7:0] b, input logic [SEL_W-1:0] p);
    return (b[7:ID_LSB] == DEV_ID[7-ID_LSB:0]) && (b[SEL_W:1] == p);
  endfunction

  always_comb begin
    hit = id_match(sel_byte, sel_pins);
    rd  = sel_byte[0];
  end
endmodule

// File: rtl/fram_addr_latch.sv
module fram_addr_latch #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_q;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      if (ld_hi) hi_q <= byte_in[HI_W-1:0];
      if (ld_lo) addr_q <= {hi_q, byte_in};
      else if (inc) addr_q <= addr_step(addr_q);
    end
  end
endmodule

// File: rtl/fram_wp_guard.sv
module fram_wp_guard #(
  parameter int ADDR_W = 13,
  parameter bit PROT_EN = 1'b1
) (
  input  logic              wp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  function automatic logic in_top_quarter(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] & a[ADDR_W-2];
  endfunction

  generate
    if (PROT_EN) begin : g_guard
      always_comb prot = wp & in_top_quarter(addr);
    end else begin : g_open
      always_comb prot = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fram_txn_fsm.sv
module fram_txn_fsm
  import fram_txn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_start,
  input  logic    ev_stop,
  input  logic    ev_byte_vld,
  input  logic    ev_tx_done,
  input  logic    ev_mack_vld,
  input  logic    ev_mack_ok,
  input  logic    sel_hit,
  input  logic    sel_rd,
  input  logic    prot,
  output txn_st_t st_q,
  output logic    resp_vld,
  output logic    resp_ok,
  output logic    ld_hi,
  output logic    ld_lo,
  output logic    wr_go,
  output logic    wr_blocked,
  output logic    addr_inc
);
  txn_st_t st_d;

  always_comb begin
    st_d       = st_q;
    resp_vld   = 1'b0;
    resp_ok    = 1'b0;
    ld_hi      = 1'b0;
    ld_lo      = 1'b0;
    wr_go      = 1'b0;
    wr_blocked = 1'b0;
    addr_inc   = 1'b0;
    if (ev_stop) begin
      st_d = ST_IDLE;
    end else if (ev_start) begin
      st_d = ST_SEL;
    end else begin
      resp_vld = ev_byte_vld;
      unique case (st_q)
        ST_SEL: if (ev_byte_vld) begin
          resp_ok = sel_hit;
          if (!sel_hit)   st_d = ST_SKIP;
          else if (sel_rd) st_d = ST_RDAT;
          else            st_d = ST_AHI;
        end
        ST_AHI: if (ev_byte_vld) begin
          resp_ok = 1'b1;
          ld_hi   = 1'b1;
          st_d    = ST_ALO;
        end
        ST_ALO: if (ev_byte_vld) begin
          resp_ok = 1'b1;
          ld_lo   = 1'b1;
          st_d    = ST_WDAT;
        end
        ST_WDAT: if (ev_byte_vld) begin
          if (prot) begin
            wr_blocked = 1'b1;
            st_d       = ST_SKIP;
          end else begin
            resp_ok  = 1'b1;
            wr_go    = 1'b1;
            addr_inc = 1'b1;
          end
        end
        ST_RDAT: begin
          if (ev_tx_done) addr_inc = 1'b1;
          if (ev_mack_vld && !ev_mack_ok) st_d = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/fram_txn_ctrl.sv
module fram_txn_ctrl
  import fram_txn_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SEL_W = 3,
  parameter logic [3:0] DEV_ID = 4'b1010,
  parameter bit PROT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_pins,
  input  logic              wp,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte_vld,
  input  logic [7:0]        ev_byte,
  input  logic              ev_tx_done,
  input  logic              ev_mack_vld,
  input  logic              ev_mack_ok,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic              tx_en,
  output logic [7:0]        tx_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  txn_st_t st_q;
  logic sel_hit, sel_rd, prot;
  logic resp_vld, resp_ok, ld_hi, ld_lo, wr_go;
  logic wr_blocked, addr_inc;
  logic [ADDR_W-1:0] addr_q;

  fram_devsel_dec #(.SEL_W(SEL_W), .DEV_ID(DEV_ID)) u_dec (
    .sel_byte(ev_byte), .sel_pins(sel_pins), .hit(sel_hit), .rd(sel_rd)
  );

  fram_wp_guard #(.ADDR_W(ADDR_W), .PROT_EN(PROT_EN)) u_guard (
    .wp(wp), .addr(addr_q), .prot(prot)
  );

  fram_txn_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_vld(ev_byte_vld),
    .ev_tx_done(ev_tx_done), .ev_mack_vld(ev_mack_vld), .ev_mack_ok(ev_mack_ok),
    .sel_hit(sel_hit), .sel_rd(sel_rd), .prot(prot),
    .st_q(st_q), .resp_vld(resp_vld), .resp_ok(resp_ok),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .wr_go(wr_go),
    .wr_blocked(wr_blocked), .addr_inc(addr_inc)
  );

  fram_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .inc(addr_inc), .byte_in(ev_byte), .addr_q(addr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
    end else begin
      ack_vld <= resp_vld;
      ack_ok  <= resp_vld & resp_ok;
    end
  end

  always_comb begin
    ram_addr  = addr_q;
    ram_we    = wr_go;
    ram_wdata = ev_byte;
    tx_en     = (st_q == ST_RDAT);
    tx_data   = ram_rdata;
  end
endmodule

// File: rtl/fram_txn_ctrl_chk.sv
module fram_txn_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp,
  input logic              ev_stop,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ack_vld,
  input logic              ack_ok,
  input logic              tx_en,
  input logic              wr_blocked,
  input logic              addr_inc
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  // R4: a committed write is acknowledged on the next clock
  a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (ack_vld && ack_ok));

  // R4: every advance moves the latch by exactly one
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

  // R5: the top address wraps to zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_inc && ram_addr == TOP_ADDR) |=> (ram_addr == '0));

  // R6: no write lands in the protected quarter
  a_r6_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && ram_addr[ADDR_W-1] && ram_addr[ADDR_W-2]) |-> !ram_we);

  // R6: a refused data byte is nacked and leaves the latch in place
  a_r6_block_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (ack_vld && !ack_ok && $stable(ram_addr)));

  // R9: a Stop ends any read phase
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !tx_en);
endmodule

bind fram_txn_ctrl fram_txn_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .ev_stop(ev_stop),
  .ram_we(ram_we), .ram_addr(ram_addr), .ack_vld(ack_vld), .ack_ok(ack_ok),
  .tx_en(tx_en), .wr_blocked(wr_blocked), .addr_inc(addr_inc)
);

// File: tb/tb_fram_txn_ctrl.sv
module tb_fram_txn_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] SEL_W_BYTE = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] SEL_R_BYTE = {4'b1010, PINS, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, ev_byte_vld = 1'b0;
  logic [7:0] ev_byte = '0;
  logic ev_tx_done = 1'b0, ev_mack_vld = 1'b0, ev_mack_ok = 1'b0;
  logic ack_vld, ack_ok, tx_en, ram_we;
  logic [7:0] tx_data, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;
  logic [7:0] mem [DEPTH];

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fram_txn_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_pins(PINS), .wp(wp),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_vld(ev_byte_vld),
    .ev_byte(ev_byte), .ev_tx_done(ev_tx_done), .ev_mack_vld(ev_mack_vld),
    .ev_mack_ok(ev_mack_ok), .ack_vld(ack_vld), .ack_ok(ack_ok),
    .tx_en(tx_en), .tx_data(tx_data), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  function automatic logic [7:0] seed(input int a);
    return 8'(a * 7 + 3) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ok, input string rq);
    @(negedge clk) begin ev_byte = b; ev_byte_vld = 1'b1; end
    @(negedge clk) ev_byte_vld = 1'b0;
    check(ack_vld === 1'b1 && ack_ok === exp_ok, rq, {ack_vld, ack_ok}, {1'b1, exp_ok});
    @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] exp, input bit mack, input string rq);
    check(tx_en === 1'b1 && tx_data === exp, rq, {tx_en, tx_data}, {1'b1, exp});
    pulse(ev_tx_done);
    ev_mack_ok = mack;
    pulse(ev_mack_vld);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string rq);
    pulse(ev_start);
    send(SEL_W_BYTE, 1'b1, rq);
    send(hi, 1'b1, rq);
    send(lo, 1'b1, rq);
  endtask

  // R1, R10: reset state, idle byte refused, first read from address 0
  task automatic t_reset_read();
    check(ram_addr == 0 && !ack_vld && !tx_en, "R1", {tx_en, ack_vld, ram_addr}, 0);
    send(SEL_R_BYTE, 1'b0, "R10");
    check(!tx_en, "R10", tx_en, 0);
    pulse(ev_start);
    send(SEL_R_BYTE, 1'b1, "R2");
    recv(seed(0), 1'b0, "R1");
    check(!tx_en, "R7", tx_en, 0);
    pulse(ev_stop);
  endtask

  // R3, R4: high byte with garbage upper bits, three data bytes
  task automatic t_write_seq();
    set_addr(8'hE1, 8'h23, "R3");
    send(8'hAA, 1'b1, "R4");
    send(8'hBB, 1'b1, "R4");
    send(8'hCC, 1'b1, "R4");
    pulse(ev_stop);
    check(mem[11'h123] == 8'hAA && mem[11'h124] == 8'hBB && mem[11'h125] == 8'hCC,
          "R4", mem[11'h125], 8'hCC);
    check(ram_addr == 11'h126, "R3", ram_addr, 11'h126);
  endtask

  // R11, R7: current address persists; sequential read
  task automatic t_current_read();
    pulse(ev_start);
    send(SEL_R_BYTE, 1'b1, "R11");
    recv(seed(11'h126), 1'b1, "R11");
    recv(seed(11'h127), 1'b1, "R7");
    recv(seed(11'h128), 1'b0, "R7");
    check(!tx_en && ram_addr == 11'h129, "R7", ram_addr, 11'h129);
    pulse(ev_stop);
  endtask

  // R8: random read via repeated Start
  task automatic t_random_read();
    set_addr(8'h01, 8'h24, "R8");
    pulse(ev_start);
    send(SEL_R_BYTE, 1'b1, "R8");
    recv(8'hBB, 1'b1, "R8");
    recv(8'hCC, 1'b0, "R8");
    pulse(ev_stop);
    check(mem[11'h124] == 8'hBB, "R8", mem[11'h124], 8'hBB);
  endtask

  // R2: wrong strap bits and wrong type nibble are refused, nothing written
  task automatic t_mismatch();
    pulse(ev_start);
    send({4'b1010, 3'b001, 1'b0}, 1'b0, "R2");
    send(8'h00, 1'b0, "R2");
    send(8'h10, 1'b0, "R2");
    send(8'h77, 1'b0, "R2");
    pulse(ev_start);
    send({4'b1011, PINS, 1'b1}, 1'b0, "R2");
    check(!tx_en, "R2", tx_en, 0);
    pulse(ev_stop);
    check(mem[11'h010] == seed(11'h010), "R2", mem[11'h010], seed(11'h010));
  endtask

  // R5, R6: wrap at top with wp low, top quarter writable
  task automatic t_wrap();
    wp = 1'b0;
    set_addr(8'h07, 8'hFE, "R5");
    send(8'h11, 1'b1, "R6");
    send(8'h22, 1'b1, "R5");
    send(8'h33, 1'b1, "R5");
    pulse(ev_stop);
    check(mem[11'h7FE] == 8'h11 && mem[11'h7FF] == 8'h22, "R6", mem[11'h7FF], 8'h22);
    check(mem[0] == 8'h33 && ram_addr == 1, "R5", {mem[0], ram_addr}, {8'h33, 11'h1});
  endtask

  // R6, R3: protected quarter with wp high
  task automatic t_protect();
    wp = 1'b1;
    set_addr(8'h07, 8'h80, "R3");
    send(8'h44, 1'b0, "R6");
    pulse(ev_stop);
    check(mem[11'h780] == seed(11'h780) && ram_addr == 11'h780, "R6", ram_addr, 11'h780);
    set_addr(8'h05, 8'hFF, "R6");
    send(8'h55, 1'b1, "R6");
    send(8'h66, 1'b0, "R6");
    send(8'h67, 1'b0, "R6");
    pulse(ev_stop);
    check(mem[11'h5FF] == 8'h55 && mem[11'h600] == seed(11'h600), "R6",
          mem[11'h600], seed(11'h600));
    pulse(ev_start);
    send(SEL_R_BYTE, 1'b1, "R6");
    recv(seed(11'h600), 1'b0, "R6");
    pulse(ev_stop);
    wp = 1'b0;
  endtask

  // R9, R10: abort before data completes, bytes after Stop refused
  task automatic t_abort();
    set_addr(8'h02, 8'h40, "R9");
    pulse(ev_stop);
    send(8'h99, 1'b0, "R10");
    check(mem[11'h240] == seed(11'h240) && !tx_en, "R9", mem[11'h240], seed(11'h240));
    set_addr(8'h02, 8'h41, "R9");
    pulse(ev_start);
    send(8'h12, 1'b0, "R9");
    pulse(ev_stop);
    check(mem[11'h241] == seed(11'h241), "R9", mem[11'h241], seed(11'h241));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = seed(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_read();
    t_write_seq();
    t_current_read();
    t_random_read();
    t_mismatch();
    t_wrap();
    t_protect();
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule